// File: doc/BRIEF.md
# Byte-Programming Controller for a One-Time-Programmable Code Array

This block programs and verifies a 4K-byte one-time-programmable code store over a parallel interface. Programming mode is entered when the device reset pin is held high and the program-store enable pin is held low. A four-bit selector, made of two high-port bits and two port-3 bits, then picks the operation: code byte write, code verify, lock bit 1 write, lock bit 2 write, or signature read. The 12-bit address is formed from the eight low-port pins and four high-port pins. The write data comes in on an 8-bit input.

A rising edge on the active-low program pulse starts a self-timed write of the captured byte or lock bit. While the write runs, the controller holds a ready/busy output low. A verify read of the address being written returns the written byte with bit 7 inverted, so the write can be polled on the data bus. Writes need the programming-voltage-present flag. Lock bits restrict further code writes and verify readout. The signature bytes can always be read. The write duration is a parameter counted in system clocks.

Top module: `otp_prog_ctrl`

## Requirements
- R1: `data_oe_o` is 1 only when `dev_rst_i`=1, `pse_n_i`=0 and the selected operation is verify or signature read. Whenever `data_oe_o` is 0, `data_o` is 8'h00.
- R2: The operation is selected by {`sel_hi_i[1]`,`sel_hi_i[0]`,`sel_lo_i[1]`,`sel_lo_i[0]`} as follows: 4'b0111 writes a code byte, 4'b0011 verifies code, 4'b1111 writes lock bit 1, 4'b1100 writes lock bit 2, and 4'b0000 reads the signature. Any other code is a no-op: it drives no output and a program pulse under it starts no write.
- R3: The array address is {`addr_hi_i`,`addr_lo_i`} and covers 0x000 to 0xFFF.
- R4: When a rising edge of `prog_n_i` is accepted, `rdy_o` goes low from the next clock. It stays low for exactly WRITE_CYC clocks. The byte is then committed.
- R5: During a code write, a verify of the address being written returns {~d[7], d[6:0]}, where d is the written byte. Once `rdy_o` is high again, the verify returns d.
- R6: A program pulse that arrives while `rdy_o` is low is ignored. It does not lengthen the busy time and does not change the byte being written.
- R7: With `vpp_ok_i`=0, a program pulse starts no write: `rdy_o` stays high and the array is unchanged.
- R8: Once lock bit 1 is programmed, code writes are refused and verify returns 8'hFF.
- R9: Once lock bit 2 is programmed, verify returns 8'hFF, but code writes are still accepted.
- R10: A signature read returns 8'h1E at address 0x030, 8'h87 at 0x031, 8'h03 at 0x032, and 8'hFF at any other address, whatever the lock state.
- R11: After `rst_ni` is asserted, `rdy_o` is 1 and both lock bits are unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dev_rst_i | input | 1 | Device reset pin, must be high for programming |
| pse_n_i | input | 1 | Program-store enable pin, must be low for programming |
| sel_hi_i | input | 2 | High-port operation select bits |
| sel_lo_i | input | 2 | Port-3 operation select bits |
| vpp_ok_i | input | 1 | Programming voltage present |
| prog_n_i | input | 1 | Active-low program pulse |
| addr_lo_i | input | 8 | Address bits 7:0 |
| addr_hi_i | input | ADDR_W-8 | Upper address bits |
| data_i | input | 8 | Byte to write |
| data_o | output | 8 | Verify / signature / polling data |
| data_oe_o | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | High when ready, low while a write runs |

## Verification
The hardest case to reach is a second program pulse that lands inside a running write, with new data on the input, followed by a check that neither the busy length nor the stored byte changed. The bench starts a write and changes the data while the write is busy. It then issues a full second pulse well before the write ends, measures the low time of `rdy_o`, and reads the byte back. Polling is reached in a similar way: the selector is switched to verify in the cycle right after the write starts, and the bench reads the pending address while it is still busy.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int DATA_W   = 8;
  localparam int SIG_N    = 3;
  localparam int SIG_BASE = 'h030;
  localparam logic [DATA_W-1:0] SIG_VAL [SIG_N] = '{8'h1E, 8'h87, 8'h03};

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_VERIFY, OP_LOCK1, OP_LOCK2, OP_SIG
  } op_e;

  function automatic op_e sel_to_op(logic [3:0] sel);
    case (sel)
      4'b0111: return OP_WRITE;
      4'b0011: return OP_VERIFY;
      4'b1111: return OP_LOCK1;
      4'b1100: return OP_LOCK2;
      4'b0000: return OP_SIG;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_prog_pkg::*;
(
  input  logic       dev_rst_i,
  input  logic       pse_n_i,
  input  logic [3:0] sel_i,
  output op_e        op_o
);
  always_comb op_o = (dev_rst_i && !pse_n_i) ? sel_to_op(sel_i) : OP_NONE;
endmodule

// File: rtl/otp_write_timer.sv
module otp_write_timer #(
  parameter int WRITE_CYC = 150000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WRITE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNT_W'(WRITE_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WRITE_CYC)); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R4
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R6
endmodule

// File: rtl/otp_array.sv
module otp_array
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  input  logic              busy_i,
  output logic [1:0]        lock_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  op_e               pend_op_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;
  logic [1:0]        lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_op_q   <= OP_NONE;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else if (start_i) begin
      pend_op_q   <= op_i;
      pend_addr_q <= addr_i;
      pend_data_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 2'b00;
    else if (commit_i) begin
      if (pend_op_q == OP_LOCK1) lock_q[0] <= 1'b1;
      if (pend_op_q == OP_LOCK2) lock_q[1] <= 1'b1;
    end
  end

  // behavioural store, no reset
  always_ff @(posedge clk_i) begin
    if (commit_i && pend_op_q == OP_WRITE) mem[pend_addr_q] <= pend_data_q;
  end

  always_comb begin
    rd_data_o = '1;
    if (op_i == OP_SIG) begin
      for (int k = 0; k < SIG_N; k++)
        if (addr_i == ADDR_W'(SIG_BASE + k)) rd_data_o = SIG_VAL[k];
    end else if (op_i == OP_VERIFY && lock_q == 2'b00) begin
      if (busy_i && pend_op_q == OP_WRITE && addr_i == pend_addr_q)
        rd_data_o = {~pend_data_q[DATA_W-1], pend_data_q[DATA_W-2:0]};
      else
        rd_data_o = mem[addr_i];
    end
  end

  assign lock_o = lock_q;

  AST_LOCK1_BLOCKS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && pend_op_q == OP_WRITE |-> !lock_q[0]); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q[0] |=> lock_q[0]); // R8
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 150000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_i,
  input  logic              pse_n_i,
  input  logic [1:0]        sel_hi_i,
  input  logic [1:0]        sel_lo_i,
  input  logic              vpp_ok_i,
  input  logic              prog_n_i,
  input  logic [7:0]        addr_lo_i,
  input  logic [ADDR_W-9:0] addr_hi_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              rdy_o
);
  op_e               op;
  logic              prog_q, prog_rise, start, busy, done;
  logic [1:0]        lock;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] addr;

  assign addr = {addr_hi_i, addr_lo_i};

  otp_mode_dec u_dec (
    .dev_rst_i (dev_rst_i),
    .pse_n_i   (pse_n_i),
    .sel_i     ({sel_hi_i, sel_lo_i}),
    .op_o      (op)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_q <= 1'b1;
    else         prog_q <= prog_n_i;
  end
  assign prog_rise = prog_n_i & ~prog_q;

  assign start = prog_rise && !busy && vpp_ok_i &&
                 ((op == OP_WRITE && !lock[0]) || op == OP_LOCK1 || op == OP_LOCK2);

  otp_write_timer #(.WRITE_CYC(WRITE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done)
  );

  otp_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_i      (op),
    .addr_i    (addr),
    .data_i    (data_i),
    .commit_i  (done),
    .busy_i    (busy),
    .lock_o    (lock),
    .rd_data_o (rd_data)
  );

  assign data_oe_o = (op == OP_VERIFY) || (op == OP_SIG);
  assign data_o    = data_oe_o ? rd_data : 8'h00;
  assign rdy_o     = !busy;

  AST_OE_PROG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> dev_rst_i && !pse_n_i); // R1
  AST_BUSY_NEEDS_VPP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(vpp_ok_i)); // R7
endmodule

// File: tb/otp_prog_ctrl_tb.sv
`timescale 1ns/1ps
module otp_prog_ctrl_tb;
  localparam int W = 20;

  logic clk = 0, rst_ni = 0;
  logic dev_rst = 1, pse_n = 0, vpp = 1, prog_n = 1;
  logic [3:0] sel = 4'b1010;
  logic [11:0] addr = 0;
  logic [7:0] wdata = 0, data_o;
  logic data_oe_o, rdy_o;

  always #5 clk = ~clk;

  otp_prog_ctrl #(.ADDR_W(12), .WRITE_CYC(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dev_rst_i(dev_rst), .pse_n_i(pse_n),
    .sel_hi_i(sel[3:2]), .sel_lo_i(sel[1:0]), .vpp_ok_i(vpp), .prog_n_i(prog_n),
    .addr_lo_i(addr[7:0]), .addr_hi_i(addr[11:8]), .data_i(wdata),
    .data_o(data_o), .data_oe_o(data_oe_o), .rdy_o(rdy_o));

  localparam logic [3:0] S_WR = 4'b0111, S_VF = 4'b0011, S_L1 = 4'b1111,
                         S_L2 = 4'b1100, S_SG = 4'b0000, S_NO = 4'b1010;

  int n_chk = 0, n_fail = 0, low_cnt = 0;
  bit fin = 0;
  string cur_req = "R11";

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // reference model
  int m_busy = 0, m_pop = 0, m_paddr = 0;
  logic [7:0] m_pdata = 0;
  bit m_lk1 = 0, m_lk2 = 0, m_prev = 1;
  logic [7:0] m_mem [int];

  function automatic int op_of();
    if (!(dev_rst && !pse_n)) return 0;
    case (sel)
      S_WR: return 1;  S_VF: return 2;  S_L1: return 3;
      S_L2: return 4;  S_SG: return 5;  default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 0; m_lk1 = 0; m_lk2 = 0; m_prev = 1;
    end else begin
      int o;
      bit rise;
      o = op_of();
      rise = prog_n && !m_prev;
      m_prev = prog_n;
      if (m_busy > 0) begin
        if (m_busy == 1) begin
          if (m_pop == 1) m_mem[m_paddr] = m_pdata;
          if (m_pop == 3) m_lk1 = 1;
          if (m_pop == 4) m_lk2 = 1;
        end
        m_busy--;
      end else if (rise && vpp && ((o == 1 && !m_lk1) || o == 3 || o == 4)) begin
        m_busy = W; m_pop = o; m_paddr = addr; m_pdata = wdata;
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_ni && !fin) begin
      int o;
      bit known;
      logic [7:0] ed;
      o = op_of();
      known = 1; ed = 8'h00;
      if (o == 5) begin
        ed = (addr == 12'h030) ? 8'h1E : (addr == 12'h031) ? 8'h87 :
             (addr == 12'h032) ? 8'h03 : 8'hFF;
      end else if (o == 2) begin
        if (m_lk1 || m_lk2) ed = 8'hFF;
        else if (m_busy > 0 && m_pop == 1 && int'(addr) == m_paddr) ed = {~m_pdata[7], m_pdata[6:0]};
        else if (m_mem.exists(int'(addr))) ed = m_mem[int'(addr)];
        else known = 0;
      end
      chk(cur_req, "rdy_o", rdy_o, m_busy == 0);
      chk(cur_req, "data_oe_o", data_oe_o, (o == 2 || o == 5));
      if (known) chk(cur_req, "data_o", data_o, ed);
      if (!rdy_o) low_cnt++;
    end
  end

  task automatic setup(logic [3:0] s, int a, logic [7:0] d);
    @(negedge clk); sel = s; addr = 12'(a); wdata = d;
  endtask

  task automatic pulse();
    @(negedge clk); prog_n = 0;
    repeat (2) @(negedge clk);
    prog_n = 1;
  endtask

  task automatic wait_ready();
    int g = 0;
    @(negedge clk); #2;
    while (!rdy_o && g < 1000) begin @(negedge clk); #2; g++; end
  endtask

  task automatic write(string req, int a, logic [7:0] d, int exp_low);
    setup(S_WR, a, d);
    low_cnt = 0;
    pulse();
    wait_ready();
    repeat (2) @(negedge clk);
    #2 chk(req, "busy cycles", low_cnt, exp_low);
  endtask

  task automatic rd(string req, logic [3:0] s, int a, logic [7:0] exp);
    setup(s, a, 8'h00);
    #2 chk(req, "read", data_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R11", "rdy after reset", rdy_o, 1);
    chk("R2", "no-op code oe", data_oe_o, 0);
    rst_ni = 1;

    cur_req = "R1";
    @(negedge clk); dev_rst = 0; sel = S_VF;
    #2 chk("R1", "oe outside prog mode", data_oe_o, 0);
    chk("R1", "data outside prog mode", data_o, 0);
    @(negedge clk); dev_rst = 1; pse_n = 1;
    #2 chk("R1", "oe with pse high", data_oe_o, 0);
    @(negedge clk); pse_n = 0;

    cur_req = "R10";
    rd("R10", S_SG, 'h030, 8'h1E);
    rd("R10", S_SG, 'h031, 8'h87);
    rd("R10", S_SG, 'h032, 8'h03);
    rd("R10", S_SG, 'h033, 8'hFF);
    rd("R3", S_SG, 'h130, 8'hFF);

    cur_req = "R4";
    write("R4", 'h2A7, 8'h3C, W);
    rd("R4", S_VF, 'h2A7, 8'h3C);

    cur_req = "R5";
    setup(S_WR, 'h155, 8'hC3);
    pulse();
    @(negedge clk); sel = S_VF;
    #2 chk("R5", "poll value", data_o, 8'h43);
    chk("R5", "busy during poll", rdy_o, 0);
    wait_ready();
    rd("R5", S_VF, 'h155, 8'hC3);

    cur_req = "R6";
    setup(S_WR, 'h0A0, 8'h11);
    low_cnt = 0;
    pulse();
    @(negedge clk); wdata = 8'h99;
    pulse();
    wait_ready();
    repeat (2) @(negedge clk);
    #2 chk("R6", "busy cycles with second pulse", low_cnt, W);
    rd("R6", S_VF, 'h0A0, 8'h11);

    cur_req = "R7";
    @(negedge clk); vpp = 0;
    write("R7", 'h2A7, 8'h00, 0);
    rd("R7", S_VF, 'h2A7, 8'h3C);
    @(negedge clk); vpp = 1;

    cur_req = "R3";
    write("R3", 'h000, 8'h5A, W);
    write("R3", 'hFFF, 8'hA5, W);
    rd("R3", S_VF, 'h000, 8'h5A);
    rd("R3", S_VF, 'hFFF, 8'hA5);

    cur_req = "R2";
    setup(S_NO, 'h000, 8'h77);
    low_cnt = 0;
    pulse();
    repeat (3) @(negedge clk);
    #2 chk("R2", "no-op code starts nothing", low_cnt, 0);
    chk("R2", "no-op code oe", data_oe_o, 0);
    rd("R2", S_VF, 'h000, 8'h5A);

    cur_req = "R9";
    setup(S_L2, 0, 0);
    low_cnt = 0; pulse(); wait_ready();
    rd("R9", S_VF, 'h000, 8'hFF);
    write("R9", 'h300, 8'h42, W);
    rd("R10", S_SG, 'h031, 8'h87);

    cur_req = "R11";
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    rd("R11", S_VF, 'h300, 8'h42);

    cur_req = "R8";
    setup(S_L1, 0, 0);
    low_cnt = 0; pulse(); wait_ready();
    rd("R8", S_VF, 'h300, 8'hFF);
    write("R8", 'h301, 8'h24, 0);
    rd("R10", S_SG, 'h032, 8'h03);

    repeat (3) @(negedge clk);
    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule